// File: doc/BRIEF.md
# Register-Reference Instruction Executor

This block carries out the register-reference group of a 16-bit single-accumulator machine. The opcode decoder gives it three inputs: the decoded-opcode-7 line, the addressing-mode bit and the third timing step. The low twelve instruction bits also come in. The block holds the accumulator and the one-bit extend flag. In the execute step it clears, complements, rotates or increments them. It tests them for the conditional skips, and it stops the machine on a halt. Each of the twelve operations has its own instruction bit, so one instruction word can request several of them at the same time.

The block drives three lines for the surrounding sequencer. The program-counter increment carries out a skip. The sequence-counter clear starts the next fetch. The run line tells the sequence counter whether it may advance. Other instruction groups write the accumulator and extend flag through a load port when no register-reference execution is taking place.

Top module: `rr_exec_unit`

## Requirements
- R1: After reset the accumulator and extend flag are 0, the run line is 1, and the skip and sequence-clear outputs are 0.
- R2: An operation executes only in a cycle where opD7=1, indirectBit=0, stepT3=1 and the run line is 1. In any other cycle the accumulator and extend flag take no update from irLow, and pcIncr and seqClear stay 0.
- R3: seqClear is 1, combinationally, in every executing cycle, whatever the irLow value.
- R4: Accumulator operations: irLow bit 11 clears it, bit 9 complements it and bit 5 increments it modulo 2^16. When several accumulator operations are requested, priority is clear, then complement, then rotate right, then rotate left, then increment.
- R5: Extend-flag operations: irLow bit 10 clears it and bit 8 complements it. Priority is clear, then complement, then rotate right, then rotate left. The extend flag is changed by a rotate even when an accumulator clear or complement wins.
- R6: Bit 7 rotates the 17-bit pair right: AC takes {E, AC[15:1]} and E takes AC[0]. Bit 6 rotates it left: AC takes {AC[14:0], E} and E takes AC[15]. Right wins over left.
- R7: Skip tests use the values held before this cycle's update. Bit 4 skips when AC[15]=0, bit 3 when AC[15]=1, bit 2 when AC is zero and bit 1 when E is 0. pcIncr is the OR of all the requested tests and is driven in the executing cycle.
- R8: Bit 0 (halt) drops the run line at the next clock edge. The line then stays 0 until reset, and while it is 0 every execute strobe is ignored.
- R9: When extWrEn=1 in a cycle that is not executing, the accumulator and extend flag load extAcData and extEData at the next edge. In an executing cycle the write is ignored.
- R10: Accumulator and extend-flag results appear at the clock edge that ends the executing cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opD7 | input | 1 | Decoded opcode 7 |
| indirectBit | input | 1 | Addressing-mode bit of the instruction |
| stepT3 | input | 1 | Timing step 3 |
| irLow | input | 12 | Low instruction bits, one per operation |
| extWrEn | input | 1 | Load strobe from other instruction groups |
| extAcData | input | 16 | Accumulator load value |
| extEData | input | 1 | Extend-flag load value |
| acValue | output | 16 | Accumulator |
| eValue | output | 1 | Extend flag |
| pcIncr | output | 1 | Skip: increment program counter |
| seqClear | output | 1 | Clear the sequence counter |
| seqRun | output | 1 | Sequence counter may advance |

## Verification
Each operation is first applied alone, with operands chosen to expose its edge. A rotate runs with a 1 at the end bit, so the bit must move between E and AC. The increment wraps from all ones to zero. The sign and zero tests run with AC at 0 and at 0x8000, which separates "positive includes zero" from "strictly positive". Combined words such as clear plus complement, both rotates, extend-clear with a rotate, and a zero-skip with a clear show that the priority order holds and that the skips read the values from before the update. Strobes with the mode bit set, with the step missing, with a load in the same cycle, and after a halt show that nothing executes outside the qualifying cycle.

// File: rtl/rr_exec_pkg.sv
package rr_exec_pkg;

  localparam int OP_BITS = 12;

  // Instruction bit assigned to each operation (decoded by the sequencer side too)
  localparam int BIT_CLR_AC = 11;
  localparam int BIT_CLR_E  = 10;
  localparam int BIT_CMP_AC = 9;
  localparam int BIT_CMP_E  = 8;
  localparam int BIT_ROT_R  = 7;
  localparam int BIT_ROT_L  = 6;
  localparam int BIT_INC    = 5;
  localparam int BIT_SK_POS = 4;
  localparam int BIT_SK_NEG = 3;
  localparam int BIT_SK_ZAC = 2;
  localparam int BIT_SK_ZE  = 1;
  localparam int BIT_HALT   = 0;

  typedef struct packed {
    logic active;
    logic clrAc;
    logic cmpAc;
    logic rotR;
    logic rotL;
    logic incAc;
    logic clrE;
    logic cmpE;
  } rrStrobes_t;

endpackage

// File: rtl/rr_exec_ctrl.sv
module rr_exec_ctrl
  import rr_exec_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               opD7,
  input  logic               indirectBit,
  input  logic               stepT3,
  input  logic [OP_BITS-1:0] irLow,
  input  logic               acSign,
  input  logic               acZero,
  input  logic               eBit,
  output rrStrobes_t         strobes,
  output logic               pcIncr,
  output logic               seqClear,
  output logic               seqRun
);

  logic runQ;
  logic execNow;
  logic [3:0] skipReq;
  logic [3:0] skipCond;

  assign execNow = opD7 & ~indirectBit & stepT3 & runQ;

  always_comb begin
    strobes.active = execNow;
    strobes.clrAc  = execNow & irLow[BIT_CLR_AC];
    strobes.cmpAc  = execNow & irLow[BIT_CMP_AC];
    strobes.rotR   = execNow & irLow[BIT_ROT_R];
    strobes.rotL   = execNow & irLow[BIT_ROT_L];
    strobes.incAc  = execNow & irLow[BIT_INC];
    strobes.clrE   = execNow & irLow[BIT_CLR_E];
    strobes.cmpE   = execNow & irLow[BIT_CMP_E];
  end

  // Skip tests: request bits paired with their condition, reduced by OR
  assign skipReq  = {irLow[BIT_SK_POS], irLow[BIT_SK_NEG], irLow[BIT_SK_ZAC], irLow[BIT_SK_ZE]};
  assign skipCond = {~acSign, acSign, acZero, ~eBit};

  assign pcIncr   = execNow & |(skipReq & skipCond);
  assign seqClear = execNow;
  assign seqRun   = runQ;

  always_ff @(posedge clk) begin
    if (!rstN) runQ <= 1'b1;
    else if (execNow && irLow[BIT_HALT]) runQ <= 1'b0;
  end

  AST_HALT_DROPS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (opD7 && !indirectBit && stepT3 && seqRun && irLow[BIT_HALT]) |=> !seqRun) else $error("halt"); // R8
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !seqRun |=> !seqRun) else $error("sticky"); // R8
  AST_HALTED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !seqRun |-> (!pcIncr && !seqClear)) else $error("quiet"); // R8
  AST_SKIP_ENDS_INSN: assert property (@(posedge clk) disable iff (!rstN)
    pcIncr |-> seqClear) else $error("skip"); // R3
  AST_NO_EXEC_INDIRECT: assert property (@(posedge clk) disable iff (!rstN)
    indirectBit |-> !seqClear) else $error("indirect"); // R2

endmodule

// File: rtl/rr_exec_dpath.sv
module rr_exec_dpath
  import rr_exec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rrStrobes_t        strobes,
  input  logic              extWrEn,
  input  logic [DATA_W-1:0] extAcData,
  input  logic              extEData,
  output logic [DATA_W-1:0] acQ,
  output logic              eQ
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] acNext;
  logic              eNext;

  always_comb begin
    acNext = acQ;
    eNext  = eQ;
    if (strobes.active) begin
      if (strobes.clrAc)      acNext = '0;
      else if (strobes.cmpAc) acNext = ~acQ;
      else if (strobes.rotR)  acNext = {eQ, acQ[MSB:1]};
      else if (strobes.rotL)  acNext = {acQ[MSB-1:0], eQ};
      else if (strobes.incAc) acNext = acQ + DATA_W'(1);

      if (strobes.clrE)       eNext = 1'b0;
      else if (strobes.cmpE)  eNext = ~eQ;
      else if (strobes.rotR)  eNext = acQ[0];
      else if (strobes.rotL)  eNext = acQ[MSB];
    end else if (extWrEn) begin
      acNext = extAcData;
      eNext  = extEData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acQ <= '0;
      eQ  <= 1'b0;
    end else begin
      acQ <= acNext;
      eQ  <= eNext;
    end
  end

  AST_CLR_AC_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrAc |=> acQ == '0) else $error("clr"); // R4
  AST_ROT_R_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rotR && !strobes.clrAc && !strobes.cmpAc && !strobes.clrE && !strobes.cmpE)
    |=> (acQ == {$past(eQ), $past(acQ[MSB:1])}) && (eQ == $past(acQ[0]))) else $error("rotr"); // R6
  AST_INC_ALONE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.incAc && !strobes.clrAc && !strobes.cmpAc && !strobes.rotR && !strobes.rotL)
    |=> acQ == $past(acQ) + DATA_W'(1)) else $error("inc"); // R4
  AST_EXT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (extWrEn && !strobes.active) |=> (acQ == $past(extAcData)) && (eQ == $past(extEData))) else $error("load"); // R9
  AST_CLR_E_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrE |=> !eQ) else $error("clre"); // R5

endmodule

// File: rtl/rr_exec_unit.sv
module rr_exec_unit
  import rr_exec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opD7,
  input  logic              indirectBit,
  input  logic              stepT3,
  input  logic [11:0]       irLow,
  input  logic              extWrEn,
  input  logic [DATA_W-1:0] extAcData,
  input  logic              extEData,
  output logic [DATA_W-1:0] acValue,
  output logic              eValue,
  output logic              pcIncr,
  output logic              seqClear,
  output logic              seqRun
);

  rrStrobes_t strobes;

  rr_exec_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .opD7        (opD7),
    .indirectBit (indirectBit),
    .stepT3      (stepT3),
    .irLow       (irLow),
    .acSign      (acValue[DATA_W-1]),
    .acZero      (acValue == '0),
    .eBit        (eValue),
    .strobes     (strobes),
    .pcIncr      (pcIncr),
    .seqClear    (seqClear),
    .seqRun      (seqRun)
  );

  rr_exec_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .extWrEn   (extWrEn),
    .extAcData (extAcData),
    .extEData  (extEData),
    .acQ       (acValue),
    .eQ        (eValue)
  );

endmodule

// File: tb/rr_exec_unit_tb_top.sv
module rr_exec_unit_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN = 1'b0;
  logic        opD7 = 0, indirectBit = 0, stepT3 = 0, extWrEn = 0, extEData = 0;
  logic [11:0] irLow = '0;
  logic [15:0] extAcData = '0;
  logic [15:0] acValue;
  logic        eValue, pcIncr, seqClear, seqRun;

  rr_exec_unit dut_i (
    .clk(clk), .rstN(rstN), .opD7(opD7), .indirectBit(indirectBit), .stepT3(stepT3),
    .irLow(irLow), .extWrEn(extWrEn), .extAcData(extAcData), .extEData(extEData),
    .acValue(acValue), .eValue(eValue), .pcIncr(pcIncr), .seqClear(seqClear), .seqRun(seqRun)
  );

  typedef struct packed {
    logic        expPc;
    logic        expSc;
    logic        expRun;
    logic [15:0] expAc;
    logic        expE;
  } expItem_t;

  expItem_t expQ[$];
  string    tagQ[$];
  int vecCount = 0;
  int missCount = 0;
  bit finished = 0;

  logic [15:0] mAc;
  logic        mE, mRun;

  task automatic checkVal(input string tag, input string what, input int act, input int exp);
    vecCount++;
    if (act != exp) begin
      missCount++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Driver: drive one cycle at the falling edge and push the expectation
  task automatic apply(input logic d7, input logic ind, input logic t3, input logic [11:0] ir,
                       input logic we, input logic [15:0] wd, input logic wde, input string tag);
    expItem_t it;
    logic ex, sk;
    logic [15:0] nAc;
    logic nE;
    @(negedge clk);
    opD7 = d7; indirectBit = ind; stepT3 = t3; irLow = ir;
    extWrEn = we; extAcData = wd; extEData = wde;
    ex = d7 && !ind && t3 && mRun;
    sk = ex && ((ir[4] && !mAc[15]) || (ir[3] && mAc[15]) || (ir[2] && mAc == 16'h0) || (ir[1] && !mE));
    nAc = mAc; nE = mE;
    if (ex) begin
      if (ir[11])     nAc = 16'h0;
      else if (ir[9]) nAc = ~mAc;
      else if (ir[7]) nAc = {mE, mAc[15:1]};
      else if (ir[6]) nAc = {mAc[14:0], mE};
      else if (ir[5]) nAc = mAc + 16'h1;
      if (ir[10])     nE = 1'b0;
      else if (ir[8]) nE = ~mE;
      else if (ir[7]) nE = mAc[0];
      else if (ir[6]) nE = mAc[15];
    end else if (we) begin
      nAc = wd; nE = wde;
    end
    it.expPc = sk; it.expSc = ex; it.expRun = mRun; it.expAc = nAc; it.expE = nE;
    expQ.push_back(it);
    tagQ.push_back(tag);
    mAc = nAc; mE = nE;
    if (ex && ir[0]) mRun = 1'b0;
  endtask

  task automatic exec(input logic [11:0] ir, input string tag);
    apply(1'b1, 1'b0, 1'b1, ir, 1'b0, 16'h0, 1'b0, tag);
  endtask

  task automatic load(input logic [15:0] ac, input logic e);
    apply(1'b0, 1'b0, 1'b0, 12'h0, 1'b1, ac, e, "R9");
  endtask

  // Monitor: combinational outputs mid-cycle, registered results after the edge
  initial begin
    forever begin
      expItem_t it;
      string tg;
      @(negedge clk);
      #1;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        tg = tagQ.pop_front();
        checkVal(tg, "pcIncr", int'(pcIncr), int'(it.expPc));
        checkVal(tg, "seqClear", int'(seqClear), int'(it.expSc));
        checkVal(tg, "seqRun", int'(seqRun), int'(it.expRun));
        @(posedge clk);
        #1;
        checkVal(tg, "acValue", int'(acValue), int'(it.expAc));
        checkVal(tg, "eValue", int'(eValue), int'(it.expE));
      end
    end
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; opD7 = 0; indirectBit = 0; stepT3 = 0; irLow = '0; extWrEn = 0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    mAc = 16'h0; mE = 1'b0; mRun = 1'b1;
    #1;
    // R1 reset state
    checkVal("R1", "acValue", int'(acValue), 0);
    checkVal("R1", "eValue", int'(eValue), 0);
    checkVal("R1", "seqRun", int'(seqRun), 1);
    checkVal("R1", "pcIncr", int'(pcIncr), 0);
    checkVal("R1", "seqClear", int'(seqClear), 0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  endtask

  initial begin
    #100us;
    missCount++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish();
  end

  initial begin
    mAc = 16'h0; mE = 1'b0; mRun = 1'b1;
    doReset();

    load(16'h1234, 1'b1);
    exec(12'h800, "R4");          // clear AC
    exec(12'h400, "R5");          // clear E
    exec(12'h200, "R4");          // complement AC -> FFFF
    exec(12'h100, "R5");          // complement E -> 1
    exec(12'h020, "R4");          // FFFF+1 wraps to 0
    exec(12'h004, "R7");          // AC zero: skip
    exec(12'h010, "R7");          // AC zero counts as positive
    exec(12'h008, "R7");          // not negative: no skip
    exec(12'h002, "R7");          // E=1: no skip
    load(16'h0001, 1'b1);
    exec(12'h080, "R6");          // rotate right -> 8000, E=1
    exec(12'h008, "R7");          // negative: skip
    exec(12'h010, "R7");          // not positive
    load(16'h8000, 1'b0);
    exec(12'h040, "R6");          // rotate left -> 0000, E=1
    exec(12'h0C0, "R6");          // both rotates: right wins
    load(16'h5A5A, 1'b0);
    exec(12'hA00, "R4");          // clear beats complement
    load(16'h0003, 1'b1);
    exec(12'h480, "R5");          // E clear wins, AC still rotates
    load(16'h00F0, 1'b0);
    exec(12'h804, "R7");          // zero test sees old AC: no skip, AC cleared
    exec(12'h806, "R7");          // AC=0 and E=0 now: skip
    exec(12'h000, "R3");          // empty word still clears the sequencer
    load(16'h0F0F, 1'b1);
    apply(1'b1, 1'b1, 1'b1, 12'h800, 1'b0, 16'h0, 1'b0, "R2");   // indirect set
    apply(1'b1, 1'b0, 1'b0, 12'h200, 1'b0, 16'h0, 1'b0, "R2");   // no T3
    apply(1'b0, 1'b0, 1'b1, 12'h100, 1'b0, 16'h0, 1'b0, "R2");   // not D7
    apply(1'b1, 1'b0, 1'b1, 12'h020, 1'b1, 16'hBEEF, 1'b0, "R9"); // exec beats load
    exec(12'h021, "R8");          // increment and halt together
    exec(12'h800, "R8");          // ignored while halted
    exec(12'h004, "R8");
    load(16'h1111, 1'b0);         // load still works while halted
    exec(12'h200, "R10");
    apply(1'b0, 1'b0, 1'b0, 12'h0, 1'b0, 16'h0, 1'b0, "R10");
    repeat (4) @(negedge clk);
    doReset();                    // reset restores run
    exec(12'h200, "R10");
    apply(1'b0, 1'b0, 1'b0, 12'h0, 1'b0, 16'h0, 1'b0, "R10");
    repeat (4) @(negedge clk);
    finish();
  end

endmodule